// File: doc/BRIEF.md
# UART Modem Handshake Register Logic

This block holds the modem-handshake registers of a 16550-style serial port. A host writes an interrupt-enable register and a modem control register through a synchronous register port. The control register drives the active-low request-to-send pin and selects an internal loopback mode. The block also samples four active-low modem input pins and presents them in a modem status register. These pins are clear-to-send, data-set-ready, carrier-detect and ring-indicator.

Each status input first passes through a flop synchronizer. After that, change detection latches delta flags. For clear-to-send, data-set-ready and carrier-detect, any change sets the flag. For the ring indicator, only the trailing edge sets it. The host raises a dedicated strobe to mark the cycle in which it consumes a status-register read, and that strobe clears every delta flag. While any delta flag is set and the status interrupt is enabled, a modem-status interrupt request is held asserted. In loopback mode, the request-to-send pin is held idle and the request-to-send control bit is routed into the clear-to-send status bit, so the status path can be exercised without external wiring.

Top module: `uart_modem_ctl`

## Requirements
- R1: After reset `rtsN` is 1 and `msIrq` is 0. With all pins held high, the status register (address 6) reads 0x00.
- R2: `rtsN` is 0 exactly when control bit 1 (request-to-send) is 1 and control bit 4 (loopback) is 0; otherwise it is 1. The control register is at address 4.
- R3: Outside loopback, status bits 4, 5, 6 and 7 read the inverse of `ctsN`, `dsrN`, `riN` and `dcdN` respectively, once the synchronizer has settled.
- R4: Status bit 2 sets only when `riN` goes from low to high. A high-to-low change of `riN` leaves it unchanged.
- R5: Status bits 0, 1 and 3 set on any change of the clear-to-send, data-set-ready and carrier-detect status bits (4, 5, 7), in either direction.
- R6: A cycle with `msrRdStb` high clears all four delta bits (3:0). Until the next qualifying change, the delta bits then hold their value.
- R7: If a qualifying change reaches a delta bit in the same cycle as `msrRdStb`, that bit stays set. The other delta bits still clear.
- R8: `msIrq` is 1 exactly when interrupt-enable bit 3 (address 1) is 1 and at least one delta bit is set.
- R9: In loopback, status bit 4 follows control bit 1 and ignores `ctsN`. A change of that bit sets delta bit 0.
- R10: The interrupt-enable register (address 1) reads back its low 4 bits, and the control register (address 4) reads back its low 5 bits. The upper bits read 0.
- R11: A write to any address other than 1 or 4 changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low master reset |
| wrEn | input | 1 | Register write enable |
| addr | input | 3 | Register address for read and write |
| wrData | input | 8 | Write data |
| msrRdStb | input | 1 | Marks the cycle in which a status read is consumed; clears deltas |
| rdData | output | 8 | Combinational read data for `addr` |
| ctsN | input | 1 | Clear-to-send pin, active low |
| dsrN | input | 1 | Data-set-ready pin, active low |
| dcdN | input | 1 | Carrier-detect pin, active low |
| riN | input | 1 | Ring-indicator pin, active low |
| rtsN | output | 1 | Request-to-send pin, active low |
| msIrq | output | 1 | Modem-status interrupt request |

## Verification
On every cycle, the embedded assertions check the following:
- The request-to-send pin stays idle in loopback.
- A delta bit rises only after the matching status transition, and only for the trailing ring-indicator direction.
- A changed status bit always sets its delta.
- The clear strobe empties the deltas unless a change coincides.
- Deltas hold otherwise.
- The interrupt follows enable and deltas.

The read-back values, the exact inversion of each pin into its status bit, and the outcome of every pair of pin patterns can only be shown by the bench's scenarios. The same applies to the write-address decoding and the same-cycle collision of a read and a ring-indicator edge.

// File: rtl/uart_modem_pkg.sv
package uart_modem_pkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 3;
  localparam int NUM_LINE = 4;
  localparam int IER_W    = 4;
  localparam int MCR_W    = 5;

  localparam logic [ADDR_W-1:0] ADDR_IER = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_MCR = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_MSR = 3'd6;

  // line index inside the status vector
  localparam int LINE_CTS = 0;
  localparam int LINE_DSR = 1;
  localparam int LINE_RI  = 2;
  localparam int LINE_DCD = 3;

  localparam int MCR_RTS_BIT  = 1;
  localparam int MCR_LOOP_BIT = 4;
  localparam int IER_MSI_BIT  = 3;

  typedef struct packed {
    logic wrIer;
    logic wrMcr;
    logic clrDelta;
  } modemStrobe_t;
endpackage

// File: rtl/uart_modem_path.sv
module uart_modem_path
  import uart_modem_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_LINE-1:0] pinsN,
  input  modemStrobe_t        strb,
  input  logic                loopEn,
  input  logic                loopCts,
  output logic [DATA_W-1:0]   msr
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [NUM_LINE-1:0] syncQ [SYNC_STAGES];
  logic [NUM_LINE-1:0] statNow;
  logic [NUM_LINE-1:0] statPrev;
  logic [NUM_LINE-1:0] edgeVec;
  logic [NUM_LINE-1:0] delta;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ[0] <= '1;
    else       syncQ[0] <= pinsN;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ[s] <= '1;
      else       syncQ[s] <= syncQ[s-1];
    end
  end

  always_comb begin
    statNow = ~syncQ[LAST];
    if (loopEn) statNow[LINE_CTS] = loopCts;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statPrev <= '0;
    else       statPrev <= statNow;
  end

  for (genvar i = 0; i < NUM_LINE; i++) begin : g_edge
    if (i == LINE_RI) begin : g_trail
      // ring pin low->high means status bit falls
      assign edgeVec[i] = statPrev[i] & ~statNow[i];
    end else begin : g_any
      assign edgeVec[i] = statPrev[i] ^ statNow[i];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              delta[i] <= 1'b0;
      else if (edgeVec[i])    delta[i] <= 1'b1;
      else if (strb.clrDelta) delta[i] <= 1'b0;
    end

    // R7: a change in the clearing cycle still lands
    a_r7_edge_sets: assert property (@(posedge clk) disable iff (!rstN)
      edgeVec[i] |=> delta[i]);
  end

  assign msr = {statNow[LINE_DCD], statNow[LINE_RI], statNow[LINE_DSR],
                statNow[LINE_CTS], delta[LINE_DCD], delta[LINE_RI],
                delta[LINE_DSR], delta[LINE_CTS]};

  // R4: ring delta rises only after the status bit fell
  a_r4_ri_trailing: assert property (@(posedge clk) disable iff (!rstN)
    $rose(msr[2]) |-> (!$past(msr[6]) && $past(msr[6], 2)));

  // R5: any change of a plain status bit sets its delta
  a_r5_cts_delta: assert property (@(posedge clk) disable iff (!rstN)
    (msr[4] != $past(msr[4])) |=> msr[0]);
  a_r5_dsr_delta: assert property (@(posedge clk) disable iff (!rstN)
    (msr[5] != $past(msr[5])) |=> msr[1]);
  a_r5_dcd_delta: assert property (@(posedge clk) disable iff (!rstN)
    (msr[7] != $past(msr[7])) |=> msr[3]);

  // R6: a clear with no coincident change empties deltas, otherwise they hold
  a_r6_clear: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrDelta && edgeVec == '0) |=> (msr[3:0] == 4'b0000));
  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.clrDelta && edgeVec == '0) |=> $stable(msr[3:0]));
endmodule

// File: rtl/uart_modem_ctrl.sv
module uart_modem_ctrl
  import uart_modem_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              msrRdStb,
  input  logic [DATA_W-1:0] msrValue,
  output modemStrobe_t      strb,
  output logic              loopEn,
  output logic              loopCts,
  output logic [DATA_W-1:0] rdData,
  output logic              rtsN,
  output logic              msIrq
);
  logic [IER_W-1:0] ierReg;
  logic [MCR_W-1:0] mcrReg;
  logic             unusedWr;

  assign unusedWr = ^wrData[DATA_W-1:MCR_W];

  always_comb begin
    strb.wrIer    = wrEn && (addr == ADDR_IER);
    strb.wrMcr    = wrEn && (addr == ADDR_MCR);
    strb.clrDelta = msrRdStb;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ierReg <= '0;
      mcrReg <= '0;
    end else begin
      if (strb.wrIer) ierReg <= wrData[IER_W-1:0];
      if (strb.wrMcr) mcrReg <= wrData[MCR_W-1:0];
    end
  end

  assign loopEn  = mcrReg[MCR_LOOP_BIT];
  assign loopCts = mcrReg[MCR_RTS_BIT];
  assign rtsN    = ~(mcrReg[MCR_RTS_BIT] & ~mcrReg[MCR_LOOP_BIT]);
  assign msIrq   = ierReg[IER_MSI_BIT] & (|msrValue[NUM_LINE-1:0]);

  always_comb begin
    rdData = '0;
    case (addr)
      ADDR_IER: rdData[IER_W-1:0] = ierReg;
      ADDR_MCR: rdData[MCR_W-1:0] = mcrReg;
      ADDR_MSR: rdData            = msrValue;
      default:  rdData            = '0;
    endcase
  end

  // R2: loopback keeps the pin idle
  a_r2_loop_rts_idle: assert property (@(posedge clk) disable iff (!rstN)
    mcrReg[MCR_LOOP_BIT] |-> rtsN);
  // R9: loopback routes request-to-send into clear-to-send status
  a_r9_loop_cts: assert property (@(posedge clk) disable iff (!rstN)
    mcrReg[MCR_LOOP_BIT] |-> (msrValue[4] == mcrReg[MCR_RTS_BIT]));
  // R8: interrupt needs the enable, and fires when a delta appears
  a_r8_irq_enable: assert property (@(posedge clk) disable iff (!rstN)
    msIrq |-> ierReg[IER_MSI_BIT]);
  a_r8_irq_raise: assert property (@(posedge clk) disable iff (!rstN)
    (ierReg[IER_MSI_BIT] && $rose(msrValue[0])) |-> msIrq);
endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl
  import uart_modem_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              msrRdStb,
  output logic [DATA_W-1:0] rdData,
  input  logic              ctsN,
  input  logic              dsrN,
  input  logic              dcdN,
  input  logic              riN,
  output logic              rtsN,
  output logic              msIrq
);
  modemStrobe_t      strb;
  logic              loopEn;
  logic              loopCts;
  logic [DATA_W-1:0] msrValue;
  logic [NUM_LINE-1:0] pinsN;

  assign pinsN = {dcdN, riN, dsrN, ctsN};

  uart_modem_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .addr     (addr),
    .wrData   (wrData),
    .msrRdStb (msrRdStb),
    .msrValue (msrValue),
    .strb     (strb),
    .loopEn   (loopEn),
    .loopCts  (loopCts),
    .rdData   (rdData),
    .rtsN     (rtsN),
    .msIrq    (msIrq)
  );

  uart_modem_path #(.SYNC_STAGES(SYNC_STAGES)) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .pinsN   (pinsN),
    .strb    (strb),
    .loopEn  (loopEn),
    .loopCts (loopCts),
    .msr     (msrValue)
  );
endmodule

// File: tb/tb_uart_modem_ctl.sv
module tb_uart_modem_ctl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] addr = 3'd6;
  logic [7:0] wrData = 8'h00;
  logic       msrRdStb = 1'b0;
  logic [7:0] rdData;
  logic       ctsN = 1'b1, dsrN = 1'b1, dcdN = 1'b1, riN = 1'b1;
  logic       rtsN, msIrq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  uart_modem_ctl dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .msrRdStb(msrRdStb), .rdData(rdData), .ctsN(ctsN), .dsrN(dsrN),
    .dcdN(dcdN), .riN(riN), .rtsN(rtsN), .msIrq(msIrq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [7:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    tick(1);
    wrEn = 1'b0; addr = 3'd6;
  endtask

  task automatic readReg(input logic [2:0] a, output logic [7:0] d);
    addr = a; #1; d = rdData; addr = 3'd6;
  endtask

  task automatic clearMsr();
    msrRdStb = 1'b1; tick(1); msrRdStb = 1'b0;
  endtask

  task automatic setPins(input logic [3:0] p);
    {dcdN, riN, dsrN, ctsN} = p;
  endtask

  initial begin
    logic [7:0] v;
    tick(3);
    rstN = 1'b1;
    tick(1);
    // R1 reset state
    check("R1 rtsN", {7'b0, rtsN}, 8'h01);
    check("R1 msIrq", {7'b0, msIrq}, 8'h00);
    readReg(3'd6, v); check("R1 msr", v, 8'h00);

    // R10 readback
    writeReg(3'd1, 8'hFF); readReg(3'd1, v); check("R10 ier", v, 8'h0F);
    writeReg(3'd4, 8'hFF); readReg(3'd4, v); check("R10 mcr", v, 8'h1F);
    // R11 other addresses ignored
    writeReg(3'd2, 8'h00); writeReg(3'd6, 8'h00); writeReg(3'd7, 8'h00);
    readReg(3'd1, v); check("R11 ier kept", v, 8'h0F);
    readReg(3'd4, v); check("R11 mcr kept", v, 8'h1F);
    // R2 loop overrides rts
    check("R2 loop rts", {7'b0, rtsN}, 8'h01);
    writeReg(3'd4, 8'h02); check("R2 rts on", {7'b0, rtsN}, 8'h00);
    writeReg(3'd4, 8'h00); check("R2 rts off", {7'b0, rtsN}, 8'h01);
    writeReg(3'd4, 8'h10); check("R2 loop only", {7'b0, rtsN}, 8'h01);

    // R9 loopback self-test of clear-to-send status
    tick(4); clearMsr();
    ctsN = 1'b0; tick(4);
    readReg(3'd6, v); check("R9 pin ignored", v & 8'h11, 8'h00);
    writeReg(3'd4, 8'h12);
    readReg(3'd6, v); check("R9 cts follows", v & 8'h10, 8'h10);
    check("R2 loop rts set", {7'b0, rtsN}, 8'h01);
    tick(1);
    readReg(3'd6, v); check("R9 delta", v & 8'h01, 8'h01);
    writeReg(3'd4, 8'h00); ctsN = 1'b1; tick(4); clearMsr();
    readReg(3'd6, v); check("R6 cleared", v, 8'h00);

    // R3 R4 R5 R8 sweep over every pair of pin patterns
    for (int a = 0; a < 16; a++) begin
      writeReg(3'd1, (a < 8) ? 8'h08 : 8'h00);
      for (int b = 0; b < 16; b++) begin
        logic [3:0] pa, pb, ch;
        logic [7:0] exp;
        pa = 4'(a); pb = 4'(b); ch = pa ^ pb;
        setPins(pa); tick(4); clearMsr();
        setPins(pb); tick(4);
        exp = {~pb[3], ~pb[2], ~pb[1], ~pb[0],
               ch[3], ~pa[2] & pb[2], ch[1], ch[0]};
        readReg(3'd6, v);
        check("R3 R4 R5 msr sweep", v, exp);
        check("R8 irq sweep", {7'b0, msIrq},
              {7'b0, (a < 8) && (exp[3:0] != 4'b0)});
      end
    end

    // R6 deltas hold without a read, then clear
    setPins(4'hF); tick(4); clearMsr();
    writeReg(3'd1, 8'h08);
    dsrN = 1'b0; tick(4); dsrN = 1'b1; tick(8);
    readReg(3'd6, v); check("R6 hold", v, 8'h02);
    check("R8 irq held", {7'b0, msIrq}, 8'h01);
    clearMsr();
    readReg(3'd6, v); check("R6 clear", v, 8'h00);
    check("R8 irq drop", {7'b0, msIrq}, 8'h00);

    // R7 ring trailing edge coinciding with the read
    riN = 1'b0; tick(4); clearMsr();
    readReg(3'd6, v); check("R4 leading no delta", v, 8'h40);
    ctsN = 1'b0; tick(4);
    riN = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    msrRdStb = 1'b1;
    @(posedge clk); @(negedge clk);
    msrRdStb = 1'b0;
    readReg(3'd6, v); check("R7 edge wins", v, 8'h14);
    clearMsr();
    readReg(3'd6, v); check("R7 later clear", v, 8'h10);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R1 watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule